// File: doc/BRIEF.md
# Xon/Xoff Software Flow Control Unit

This block carries the in-band software flow control of one serial channel. The host programs two Xon characters and two Xoff characters, and selects how they are used through a small feature register. Every byte the receiver delivers is compared against the selected characters. A matched Xoff raises a pause request towards the local transmitter. A matched Xon drops that request. When both sets are selected, a match needs the set-1 character followed by the set-2 character on two consecutive received bytes.

The transmitter reports each Xon or Xoff it has sent with a one-cycle pulse. Four sticky event flags record these two transmit events and the two receive detections. The host reads the flags through the register port, and a read of the status address clears them. An event that arrives in the same cycle as that read still remains set afterwards.

The received-byte stream uses valid/ready. `rx_ready` is held high, so the block never applies back-pressure, and every cycle with `rx_valid` high transfers one byte. The register port and the transmit-event pulses are plain control pins.

Top module: `swfc_unit`

## Requirements
- R1: After reset the four character registers, the feature register, the status flags and `tx_pause` are all zero.
- R2: Register writes behave as follows. Address 0x9 loads the feature register, which keeps `reg_wdata[4:0]`. Addresses 0xC, 0xD, 0xE and 0xF load Xoff1, Xoff2, Xon1 and Xon2. A read of 0x9 returns the feature bits with bits [7:5] zero. A read of any address other than 0x9 and 0xC, and any cycle with `reg_rd` low, returns 0 on `reg_rdata`.
- R3: A read of address 0xC returns the status with bits [7:4] zero. Bit 3 means an Xon was sent, bit 2 an Xoff was sent, bit 1 an Xon was detected on receive, and bit 0 an Xoff was detected on receive. Read data is combinational in the cycle of the read.
- R4: A status read clears all four flags at the clock edge that ends the read. A flag whose event occurs in that same cycle is set after the edge.
- R5: Feature bit 4 is the enable. While it is 0, writes to 0xC to 0xF have no effect, no event is recorded and no receive compare takes place.
- R6: Feature bits [3:2] are the transmit selection (00 none, 01 set 1, 10 set 2, 11 both). A `tx_sent_xon` or `tx_sent_xoff` pulse sets its flag only when the enable is 1 and this field is nonzero.
- R7: Feature bits [1:0] are the receive selection, with the same encoding as R6. Value 01 compares each received byte with Xoff1 and Xon1. Value 10 compares it with Xoff2 and Xon2.
- R8: With a receive selection of 11, an Xoff match needs a byte equal to Xoff1 immediately followed by a byte equal to Xoff2 on the next accepted byte. An Xon match works the same way with Xon1 and then Xon2. Any other byte in between breaks the pair.
- R9: A receive Xoff match sets `tx_pause`, and a receive Xon match clears it. Both take effect from the edge that accepts the byte. If one byte matches both, Xoff wins, and both receive flags are set.
- R10: While receive compare is inactive (enable 0 or receive selection 00), `tx_pause` is 0 from the next edge on.
- R11: `rx_ready` is 1 in every cycle, and a byte is accepted in every cycle in which `rx_valid` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data, valid while reg_rd is high |
| rx_valid | input | 1 | Received byte valid |
| rx_ready | output | 1 | Always high; no back-pressure |
| rx_data | input | 8 | Received byte |
| tx_sent_xon | input | 1 | Pulse: transmitter sent an Xon |
| tx_sent_xoff | input | 1 | Pulse: transmitter sent an Xoff |
| tx_pause | output | 1 | Request to hold the local transmitter |

## Verification
Several properties are checked on every cycle. The upper status bits read as zero. Idle read data is zero. A quiet status read leaves the flags clear, and a transmit event that coincides with a read stays recorded. The pause output rises only on an accepted byte and drops once receive compare goes inactive. Which character is compared under each selection, how the two-byte pairs are formed and broken, that writes are ignored while the enable is off, and that Xoff wins on a tie can only be shown by the bench's scenarios against its reference model.

// File: rtl/swfc_pkg.sv
package swfc_pkg;
  localparam int CHAR_W  = 8;
  localparam int ADDR_W  = 4;
  localparam int FEAT_W  = 5;
  localparam int NUM_EVT = 4;
  localparam int FEAT_EN_BIT = 4;

  localparam logic [ADDR_W-1:0] A_FEAT  = 4'h9;
  localparam logic [ADDR_W-1:0] A_XOFF1 = 4'hC;  // also the status read address
  localparam logic [ADDR_W-1:0] A_XOFF2 = 4'hD;
  localparam logic [ADDR_W-1:0] A_XON1  = 4'hE;
  localparam logic [ADDR_W-1:0] A_XON2  = 4'hF;

  // event flag positions in the status word
  localparam int EV_RX_XOFF = 0;
  localparam int EV_RX_XON  = 1;
  localparam int EV_TX_XOFF = 2;
  localparam int EV_TX_XON  = 3;

  typedef enum logic [1:0] {
    SEL_NONE = 2'b00,
    SEL_SET1 = 2'b01,
    SEL_SET2 = 2'b10,
    SEL_PAIR = 2'b11
  } sel_e;

  typedef struct packed {
    logic [CHAR_W-1:0] xoff1;
    logic [CHAR_W-1:0] xoff2;
    logic [CHAR_W-1:0] xon1;
    logic [CHAR_W-1:0] xon2;
  } chars_t;
endpackage

// File: rtl/swfc_regs.sv
module swfc_regs
  import swfc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [CHAR_W-1:0] wdata,
  output logic [FEAT_W-1:0] feat,
  output chars_t            chars
);
  logic en;
  assign en = feat[FEAT_EN_BIT];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      feat  <= '0;
      chars <= '0;
    end else if (wr_en) begin
      unique case (addr)
        A_FEAT:  feat <= wdata[FEAT_W-1:0];
        A_XOFF1: if (en) chars.xoff1 <= wdata;
        A_XOFF2: if (en) chars.xoff2 <= wdata;
        A_XON1:  if (en) chars.xon1  <= wdata;
        A_XON2:  if (en) chars.xon2  <= wdata;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/swfc_rx_match.sv
module swfc_rx_match
  import swfc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_fire,
  input  logic [CHAR_W-1:0] rx_data,
  input  chars_t            chars,
  input  sel_e              rx_sel,
  input  logic              rx_act,
  output logic              xon_hit,
  output logic              xoff_hit,
  output logic              pause
);
  logic seen_xoff1, seen_xon1;

  always_comb begin
    xon_hit  = 1'b0;
    xoff_hit = 1'b0;
    if (rx_fire && rx_act) begin
      unique case (rx_sel)
        SEL_SET1: begin
          xoff_hit = (rx_data == chars.xoff1);
          xon_hit  = (rx_data == chars.xon1);
        end
        SEL_SET2: begin
          xoff_hit = (rx_data == chars.xoff2);
          xon_hit  = (rx_data == chars.xon2);
        end
        SEL_PAIR: begin
          xoff_hit = seen_xoff1 && (rx_data == chars.xoff2);
          xon_hit  = seen_xon1  && (rx_data == chars.xon2);
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      seen_xoff1 <= 1'b0;
      seen_xon1  <= 1'b0;
      pause      <= 1'b0;
    end else begin
      if (rx_fire) begin
        seen_xoff1 <= (rx_data == chars.xoff1);
        seen_xon1  <= (rx_data == chars.xon1);
      end
      if (!rx_act)       pause <= 1'b0;
      else if (xoff_hit) pause <= 1'b1;
      else if (xon_hit)  pause <= 1'b0;
    end
  end
endmodule

// File: rtl/swfc_status.sv
module swfc_status #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic [N-1:0] set,
  output logic [N-1:0] flags
);
  for (genvar i = 0; i < N; i++) begin : g_flag
    always_ff @(posedge clk) begin
      if (!rst_n)      flags[i] <= 1'b0;
      else if (set[i]) flags[i] <= 1'b1;
      else if (clr)    flags[i] <= 1'b0;
    end
  end
endmodule

// File: rtl/swfc_unit.sv
module swfc_unit
  import swfc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [CHAR_W-1:0] reg_wdata,
  output logic [CHAR_W-1:0] reg_rdata,
  input  logic              rx_valid,
  output logic              rx_ready,
  input  logic [CHAR_W-1:0] rx_data,
  input  logic              tx_sent_xon,
  input  logic              tx_sent_xoff,
  output logic              tx_pause
);
  logic [FEAT_W-1:0]  feat;
  chars_t             chars;
  sel_e               tx_sel, rx_sel;
  logic               feat_en, rx_act, tx_rec, rx_fire;
  logic               xon_hit, xoff_hit, stat_clr;
  logic [NUM_EVT-1:0] ev_set, ev_q;

  assign rx_ready = 1'b1;
  assign rx_fire  = rx_valid && rx_ready;
  assign feat_en  = feat[FEAT_EN_BIT];
  assign tx_sel   = sel_e'(feat[3:2]);
  assign rx_sel   = sel_e'(feat[1:0]);
  assign rx_act   = feat_en && (rx_sel != SEL_NONE);
  assign tx_rec   = feat_en && (tx_sel != SEL_NONE);
  assign stat_clr = reg_rd && (reg_addr == A_XOFF1);

  swfc_regs u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(reg_wr), .addr(reg_addr),
    .wdata(reg_wdata), .feat(feat), .chars(chars)
  );

  swfc_rx_match u_match (
    .clk(clk), .rst_n(rst_n), .rx_fire(rx_fire), .rx_data(rx_data),
    .chars(chars), .rx_sel(rx_sel), .rx_act(rx_act),
    .xon_hit(xon_hit), .xoff_hit(xoff_hit), .pause(tx_pause)
  );

  always_comb begin
    ev_set             = '0;
    ev_set[EV_RX_XOFF] = xoff_hit;
    ev_set[EV_RX_XON]  = xon_hit;
    ev_set[EV_TX_XOFF] = tx_rec && tx_sent_xoff;
    ev_set[EV_TX_XON]  = tx_rec && tx_sent_xon;
  end

  swfc_status #(.N(NUM_EVT)) u_stat (
    .clk(clk), .rst_n(rst_n), .clr(stat_clr), .set(ev_set), .flags(ev_q)
  );

  always_comb begin
    reg_rdata = '0;
    if (reg_rd) begin
      if (reg_addr == A_FEAT)       reg_rdata = {{(CHAR_W-FEAT_W){1'b0}}, feat};
      else if (reg_addr == A_XOFF1) reg_rdata = {{(CHAR_W-NUM_EVT){1'b0}}, ev_q};
    end
  end
endmodule

// File: rtl/swfc_checker.sv
module swfc_checker
  import swfc_pkg::*;
(
  input logic               clk,
  input logic               rst_n,
  input logic               reg_rd,
  input logic [ADDR_W-1:0]  reg_addr,
  input logic [CHAR_W-1:0]  reg_rdata,
  input logic               rx_valid,
  input logic               tx_sent_xon,
  input logic               tx_sent_xoff,
  input logic               tx_pause,
  input logic               rx_act,
  input logic               tx_rec,
  input logic [NUM_EVT-1:0] ev_q
);
  assert_idle_rdata_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_rd |-> reg_rdata == '0);

  assert_status_upper_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && reg_addr == A_XOFF1) |-> reg_rdata[CHAR_W-1:NUM_EVT] == '0);

  assert_quiet_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && reg_addr == A_XOFF1 && !rx_valid && !tx_sent_xon && !tx_sent_xoff)
    |=> ev_q == '0);

  assert_event_kept_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_rec && tx_sent_xon) |=> ev_q[EV_TX_XON]);

  assert_tx_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!tx_rec && tx_sent_xoff && reg_rd && reg_addr == A_XOFF1) |=> !ev_q[EV_TX_XOFF]);

  assert_pause_on_byte_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_pause) |-> $past(rx_valid));

  assert_pause_release_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_act |=> !tx_pause);
endmodule

bind swfc_unit swfc_checker u_chk (
  .clk(clk), .rst_n(rst_n), .reg_rd(reg_rd), .reg_addr(reg_addr),
  .reg_rdata(reg_rdata), .rx_valid(rx_valid), .tx_sent_xon(tx_sent_xon),
  .tx_sent_xoff(tx_sent_xoff), .tx_pause(tx_pause), .rx_act(rx_act),
  .tx_rec(tx_rec), .ev_q(ev_q)
);

// File: tb/sim_swfc_unit.sv
module sim_swfc_unit;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_wr = 0, reg_rd = 0;
  logic [3:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0, reg_rdata;
  logic       rx_valid = 0, rx_ready;
  logic [7:0] rx_data = '0;
  logic       tx_sent_xon = 0, tx_sent_xoff = 0;
  logic       tx_pause;

  int checks = 0, errors = 0;
  bit done = 0;

  // reference state
  logic [4:0] m_feat;
  logic [7:0] m_c [4];   // xoff1, xoff2, xon1, xon2
  logic [3:0] m_ev;
  logic       m_pause, m_p_off, m_p_on;

  always #10 clk = ~clk;

  swfc_unit u0 (.*);

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_rdata(bit rd, logic [3:0] a);
    if (!rd) return 8'h00;
    if (a == 4'h9) return {3'b000, m_feat};
    if (a == 4'hC) return {4'h0, m_ev};
    return 8'h00;
  endfunction

  task automatic model_reset();
    m_feat = '0; m_ev = '0; m_pause = 0; m_p_off = 0; m_p_on = 0;
    for (int i = 0; i < 4; i++) m_c[i] = '0;
  endtask

  task automatic step(string tag, bit wr, bit rd, logic [3:0] a, logic [7:0] wd,
                      bit rxv, logic [7:0] rxd, bit ton, bit toff);
    bit en, ract, xoff, xon;
    logic [1:0] ts, rs;
    @(negedge clk);
    reg_wr = wr; reg_rd = rd; reg_addr = a; reg_wdata = wd;
    rx_valid = rxv; rx_data = rxd; tx_sent_xon = ton; tx_sent_xoff = toff;
    #1;
    chk({tag, " rdata"}, reg_rdata, exp_rdata(rd, a));
    chk("R9 pause", {7'd0, tx_pause}, {7'd0, m_pause});
    chk("R11 ready", {7'd0, rx_ready}, 8'd1);
    en = m_feat[4]; ts = m_feat[3:2]; rs = m_feat[1:0];
    ract = en && rs != 2'b00;
    xoff = 0; xon = 0;
    if (rxv && ract) begin
      case (rs)
        2'b01: begin xoff = rxd == m_c[0]; xon = rxd == m_c[2]; end
        2'b10: begin xoff = rxd == m_c[1]; xon = rxd == m_c[3]; end
        default: begin xoff = m_p_off && rxd == m_c[1]; xon = m_p_on && rxd == m_c[3]; end
      endcase
    end
    m_ev = ((rd && a == 4'hC) ? 4'h0 : m_ev) |
           {en && ts != 0 && ton, en && ts != 0 && toff, xon, xoff};
    if (!ract) m_pause = 0; else if (xoff) m_pause = 1; else if (xon) m_pause = 0;
    if (rxv) begin m_p_off = rxd == m_c[0]; m_p_on = rxd == m_c[2]; end
    if (wr) begin
      if (a == 4'h9) m_feat = wd[4:0];
      else if (a >= 4'hC && en) m_c[a - 4'hC] = wd;
    end
  endtask

  task automatic wr_reg(string tag, logic [3:0] a, logic [7:0] d);
    step(tag, 1, 0, a, d, 0, 0, 0, 0);
  endtask
  task automatic rd_reg(string tag, logic [3:0] a);
    step(tag, 0, 1, a, 0, 0, 0, 0, 0);
  endtask
  task automatic rx(string tag, logic [7:0] d);
    step(tag, 0, 0, 0, 0, 1, d, 0, 0);
  endtask

  task automatic finish_run();
    if (done) return;
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    void'($urandom(32'd2718));
    model_reset();
    repeat (4) @(posedge clk);
    @(negedge clk) rst_n = 1;
    // R1: reset values
    rd_reg("R1", 4'hC);
    rd_reg("R1", 4'h9);
    wr_reg("R1", 4'h9, 8'h11);        // enable, rx set 1
    rx("R1", 8'h00);                  // zero chars: Xoff and Xon both hit
    rd_reg("R9 xoff wins", 4'hC);     // expect 03, pause 1
    // R5: writes ignored while disabled
    wr_reg("R5", 4'h9, 8'h05);
    wr_reg("R5", 4'hC, 8'h13);
    step("R5", 0, 0, 0, 0, 0, 0, 1, 1);
    wr_reg("R5", 4'h9, 8'h15);
    rx("R5", 8'h13);                  // no Xoff1 match: stays zero
    rd_reg("R5", 4'hC);
    // R2: character registers
    wr_reg("R2", 4'hC, 8'h13); wr_reg("R2", 4'hD, 8'h93);
    wr_reg("R2", 4'hE, 8'h11); wr_reg("R2", 4'hF, 8'h91);
    wr_reg("R2", 4'h9, 8'hF5);
    rd_reg("R2", 4'h9);
    rd_reg("R2", 4'hA);
    rd_reg("R2", 4'h3);
    // R7: set 1 then set 2
    rx("R7", 8'h13); rd_reg("R7", 4'hC);
    rx("R7", 8'h11); rd_reg("R7", 4'hC);
    wr_reg("R7", 4'h9, 8'h16);
    rx("R7", 8'h13); rx("R7", 8'h93); rd_reg("R7", 4'hC);
    rx("R7", 8'h91); rd_reg("R7", 4'hC);
    // R4: event in the cycle of the read survives
    step("R4", 0, 1, 4'hC, 0, 0, 0, 1, 0);
    rd_reg("R4", 4'hC);
    rd_reg("R4", 4'hC);
    // R8: pair mode
    wr_reg("R8", 4'h9, 8'h1F);
    rx("R8", 8'h93); rd_reg("R8", 4'hC);
    rx("R8", 8'h13); rx("R8", 8'h93); rd_reg("R8", 4'hC);
    rx("R8", 8'h11); rx("R8", 8'h00); rx("R8", 8'h91); rd_reg("R8", 4'hC);
    rx("R8", 8'h11); rx("R8", 8'h91); rd_reg("R8", 4'hC);
    // R6: transmit selection none
    wr_reg("R6", 4'h9, 8'h13);
    step("R6", 0, 0, 0, 0, 0, 0, 1, 1);
    rd_reg("R6", 4'hC);
    wr_reg("R6", 4'h9, 8'h19);
    step("R6", 0, 0, 0, 0, 0, 0, 1, 1);
    rd_reg("R6", 4'hC);
    // R10: release on inactive compare
    rx("R10", 8'h13);
    wr_reg("R10", 4'h9, 8'h18);
    rd_reg("R10", 4'hC);
    wr_reg("R10", 4'h9, 8'h11);
    rx("R10", 8'h13);
    wr_reg("R10", 4'h9, 8'h01);
    rd_reg("R10", 4'hC);
    // random mix on a small alphabet
    for (int n = 0; n < 4000; n++) begin
      int op = $urandom_range(0, 9);
      bit wr = 0, rd = 0;
      logic [3:0] a = 4'h0;
      logic [7:0] wd = 8'h00;
      if (op == 0) begin wr = 1; a = 4'h9; wd = 8'($urandom_range(0, 31)); end
      else if (op == 1) begin wr = 1; a = 4'($urandom_range(12, 15)); wd = 8'($urandom_range(0, 3)); end
      else if (op < 5) begin rd = 1; a = (op == 4) ? 4'($urandom_range(0, 15)) : 4'hC; end
      step("R3 random", wr, rd, a, wd, 1'($urandom_range(0, 1)),
           8'($urandom_range(0, 3)), 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)));
    end
    rd_reg("R3", 4'hC);
    finish_run();
  end
endmodule